// File: doc/BRIEF.md
# Long-Coalescing Stream Write Buffer

This block takes a stream of 4-bit values and turns it into 32-bit word writes to a memory whose port accepts a write only while a rotating slot counter points at the slice that holds the target word. Two nibbles make a byte, and bytes fill a long from the lane given by the current byte address. A transfer is started with a byte address, a byte count and a policy bit. The block then accepts exactly that many bytes and ends with a one-cycle done pulse once the last write has gone out.

The policy bit chooses between two behaviours. In eager mode, whatever bytes are waiting are written at the first matching slot. When the stream outpaces the slots, the waiting bytes merge into one wider write. In coalescing mode, a write goes out only when every byte up to the next long boundary, or up to the end of the transfer, is present. As a result, only the first long of an unaligned start and the tail long can be partial.

An eight-byte holding queue lets the stream keep running while a write waits for its slice. If a byte arrives while the queue is full and no write drains it, the transfer is cut short and an overflow flag is raised.

Top module: `stream_long_writer`

## Requirements
- R1: A byte is formed from two accepted nibbles, the first in bits 3:0 and the second in bits 7:4. Byte i of a transfer is stored at byte address start_addr + i.
- R2: `wr_en` is asserted only in a cycle where `slot_idx` equals the low SLICE_W bits of `wr_addr`, the word address, which is byte address bits ADDR_W-1:2.
- R3: In eager mode (`coalesce`=0), a write is issued in any cycle where the slot matches and at least one byte is held. That write carries every held byte up to the long boundary or the end of the transfer.
- R4: In coalescing mode with a long-aligned start address, every write has `wr_be`=4'b1111, except a final tail write when the count is not a multiple of four.
- R5: In coalescing mode with an unaligned start address, only the first and the last write of a transfer may have a `wr_be` other than 4'b1111.
- R6: `wr_be` bit k enables byte lane k (data bits 8k+7:8k). The set bits are contiguous, start at lane start_addr-derived bits 1:0 of the current byte address, and never pass lane 3.
- R7: After each write, the current byte address advances by the number of enabled lanes. Over a whole transfer, every byte address in the range is written exactly once, and nothing outside the range is written.
- R8: `busy` is high from the cycle after an accepted start until the transfer ends. `done` is a one-cycle pulse in the cycle after the last write. While `busy` is low, no write is issued.
- R9: The queue holds 8 bytes. When a byte arrives while 8 are held and no write occurs in that cycle, the byte is dropped, `overflow` is set, and `done` pulses in the next cycle. `overflow` stays set until the next accepted start clears it.
- R10: A start with `byte_count`=0 pulses `done` in the next cycle and issues no write.
- R11: Nibbles presented while idle, or after `byte_count` bytes have been received, are ignored. A start pulse while a transfer is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer (taken only when idle) |
| start_addr | input | ADDR_W | Byte address of the first byte |
| byte_count | input | CNT_W | Number of bytes in the transfer |
| coalesce | input | 1 | 1 = write whole longs only, 0 = write at first slot |
| nib_valid | input | 1 | Nibble present on nib_data |
| nib_data | input | 4 | Stream nibble |
| slot_idx | input | SLICE_W | Slice currently granted by the memory rotation |
| wr_en | output | 1 | Write issued this cycle |
| wr_addr | output | ADDR_W-2 | Word address of the write |
| wr_data | output | 32 | Write data, byte lane k in bits 8k+7:8k |
| wr_be | output | 4 | Byte-lane enables |
| busy | output | 1 | Transfer running |
| done | output | 1 | One-cycle end-of-transfer pulse |
| overflow | output | 1 | Sticky queue overflow flag |

## Verification
The delicate cycle is one in which a completed byte is pushed into the queue while a write pops bytes from the queue. The queue then has to shift and append in the same step, and a full queue is not an overflow when the pop makes room. This is provoked by streaming at random densities while the slot counter rotates every cycle, so pushes and slot hits collide often at every queue depth. The outcome is judged by rebuilding memory from the observed writes and comparing it byte for byte with the nibbles that were sent. A directed case holds the slot away from the target slice, so that a push lands on a full queue with no pop, and expects the overflow flag together with the done pulse.

// File: rtl/swb_pkg.sv
package swb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } swb_state_e;

    localparam int LANES = 4;
endpackage

// File: rtl/swb_nibble_packer.sv
module swb_nibble_packer (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       take,
    input  logic [3:0] nib,
    output logic       byte_vld,
    output logic [7:0] byte_out
);
    logic       half_q;
    logic [3:0] low_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_q <= 1'b0;
            low_q  <= 4'h0;
        end else if (clear) begin
            half_q <= 1'b0;
        end else if (take) begin
            if (!half_q) low_q <= nib;
            half_q <= !half_q;
        end
    end

    assign byte_vld = take && half_q;
    assign byte_out = {nib, low_q};
endmodule

// File: rtl/swb_byte_queue.sv
module swb_byte_queue #(
    parameter int DEPTH = 8,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          push,
    input  logic [7:0]    push_byte,
    input  logic [2:0]    pop_n,
    output logic [CW-1:0] count,
    output logic [31:0]   head,
    output logic          ovf_evt
);
    logic [7:0]    mem_q [DEPTH];
    logic [7:0]    mem_n [DEPTH];
    logic [CW-1:0] count_q;
    logic          room_ok;
    logic          accept;
    int            wr_pos;

    always_comb begin
        wr_pos  = int'(count_q) - int'(pop_n);
        room_ok = wr_pos < DEPTH;
        accept  = push && room_ok;
        for (int i = 0; i < DEPTH; i++) begin
            if (i + int'(pop_n) < DEPTH) mem_n[i] = mem_q[i + int'(pop_n)];
            else                          mem_n[i] = 8'h00;
            if (accept && i == wr_pos)    mem_n[i] = push_byte;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'h00;
        end else if (clear) begin
            count_q <= '0;
        end else begin
            count_q <= count_q - CW'(pop_n) + CW'(accept);
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_n[i];
        end
    end

    generate
        for (genvar k = 0; k < 4; k++) begin : g_head
            assign head[8*k +: 8] = mem_q[k];
        end
    endgenerate

    assign count   = count_q;
    assign ovf_evt = push && !room_ok;

    assert_queue_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CW'(DEPTH));
    assert_pop_avail_R3: assert property (@(posedge clk) disable iff (!rst_n)
        CW'(pop_n) <= count_q);
endmodule

// File: rtl/swb_lane_planner.sv
module swb_lane_planner #(
    parameter int CNT_W = 12,
    parameter int QCW   = 4
) (
    input  logic [1:0]       lane,
    input  logic [CNT_W-1:0] rem,
    input  logic [QCW-1:0]   avail,
    input  logic             coalesce,
    input  logic [31:0]      head,
    output logic             ready,
    output logic [2:0]       nbytes,
    output logic [3:0]       be,
    output logic [31:0]      data
);
    logic [2:0] room;
    logic [2:0] need;
    logic [2:0] n_eager;
    int         idx;

    always_comb begin
        room    = 3'd4 - {1'b0, lane};
        need    = (rem < CNT_W'(room)) ? rem[2:0] : room;
        n_eager = (avail < QCW'(need)) ? avail[2:0] : need;
        ready   = coalesce ? ((need != 3'd0) && (avail >= QCW'(need)))
                           : (n_eager != 3'd0);
        nbytes  = !ready ? 3'd0 : (coalesce ? need : n_eager);
        be      = 4'h0;
        data    = 32'h0;
        for (int k = 0; k < 4; k++) begin
            idx = k - int'(lane);
            if (idx >= 0 && idx < int'(nbytes)) begin
                be[k]          = 1'b1;
                data[8*k +: 8] = head[8*idx +: 8];
            end
        end
    end
endmodule

// File: rtl/stream_long_writer.sv
module stream_long_writer
    import swb_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int CNT_W   = 12,
    parameter int SLICE_W = 3,
    parameter int QDEPTH  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [ADDR_W-1:0]   start_addr,
    input  logic [CNT_W-1:0]    byte_count,
    input  logic                coalesce,
    input  logic                nib_valid,
    input  logic [3:0]          nib_data,
    input  logic [SLICE_W-1:0]  slot_idx,
    output logic                wr_en,
    output logic [ADDR_W-3:0]   wr_addr,
    output logic [31:0]         wr_data,
    output logic [3:0]          wr_be,
    output logic                busy,
    output logic                done,
    output logic                overflow
);
    localparam int QCW = $clog2(QDEPTH + 1);

    swb_state_e         state_q, state_n;
    logic [ADDR_W-1:0]  addr_q;
    logic [CNT_W-1:0]   rem_q, in_left_q;
    logic               mode_q, ovf_q, first_q;

    logic               start_ok, take, byte_vld, ovf_evt;
    logic               ready, slot_hit, fire;
    logic [7:0]         byte_val;
    logic [QCW-1:0]     q_count;
    logic [31:0]        q_head, plan_data;
    logic [2:0]         nbytes, pop_n;
    logic [3:0]         plan_be;

    assign start_ok = (state_q == ST_IDLE) && start;
    assign take     = (state_q == ST_RUN) && nib_valid && (in_left_q != '0);
    assign slot_hit = (slot_idx == addr_q[2 +: SLICE_W]);
    assign fire     = (state_q == ST_RUN) && ready && slot_hit;
    assign pop_n    = fire ? nbytes : 3'd0;

    swb_nibble_packer u_pack (
        .clk(clk), .rst_n(rst_n), .clear(start_ok), .take(take),
        .nib(nib_data), .byte_vld(byte_vld), .byte_out(byte_val)
    );

    swb_byte_queue #(.DEPTH(QDEPTH), .CW(QCW)) u_queue (
        .clk(clk), .rst_n(rst_n), .clear(start_ok), .push(byte_vld),
        .push_byte(byte_val), .pop_n(pop_n), .count(q_count),
        .head(q_head), .ovf_evt(ovf_evt)
    );

    swb_lane_planner #(.CNT_W(CNT_W), .QCW(QCW)) u_plan (
        .lane(addr_q[1:0]), .rem(rem_q), .avail(q_count), .coalesce(mode_q),
        .head(q_head), .ready(ready), .nbytes(nbytes), .be(plan_be),
        .data(plan_data)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    // Next state
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_n = (byte_count == '0) ? ST_DONE : ST_RUN;
            ST_RUN: begin
                if (ovf_evt)                                    state_n = ST_DONE;
                else if (fire && rem_q == CNT_W'(nbytes))       state_n = ST_DONE;
            end
            ST_DONE: state_n = ST_IDLE;
            default: state_n = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        busy    = (state_q == ST_RUN);
        done    = (state_q == ST_DONE);
        wr_en   = fire;
        wr_addr = addr_q[ADDR_W-1:2];
        wr_data = plan_data;
        wr_be   = fire ? plan_be : 4'h0;
    end

    // Transfer bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q    <= '0;
            rem_q     <= '0;
            in_left_q <= '0;
            mode_q    <= 1'b0;
            ovf_q     <= 1'b0;
            first_q   <= 1'b0;
        end else if (start_ok) begin
            addr_q    <= start_addr;
            rem_q     <= byte_count;
            in_left_q <= byte_count;
            mode_q    <= coalesce;
            ovf_q     <= 1'b0;
            first_q   <= 1'b1;
        end else if (state_q == ST_RUN) begin
            if (fire) begin
                addr_q  <= addr_q + ADDR_W'(nbytes);
                rem_q   <= rem_q - CNT_W'(nbytes);
                first_q <= 1'b0;
            end
            if (byte_vld) in_left_q <= in_left_q - CNT_W'(1);
            if (ovf_evt)  ovf_q     <= 1'b1;
        end
    end

    assign overflow = ovf_q;

    assert_slot_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_addr[SLICE_W-1:0] == slot_idx));
    assert_aligned_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && mode_q && addr_q[1:0] == 2'd0 && rem_q >= CNT_W'(4)) |-> (wr_be == 4'hF));
    assert_middle_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && mode_q && !first_q && rem_q >= CNT_W'(4)) |-> (wr_be == 4'hF));
    assert_lane_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ((wr_be & ~(4'hF << addr_q[1:0])) == 4'h0) && (wr_be != 4'h0));
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !wr_en);
    assert_no_overflow_loss_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !start) |=> overflow);
endmodule

// File: tb/stream_long_writer_tb_top.sv
module stream_long_writer_tb_top;
    localparam int AW = 16;
    localparam int CW = 12;
    localparam int SW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic [CW-1:0] byte_count = '0;
    logic          coalesce = 1'b0;
    logic          nib_valid = 1'b0;
    logic [3:0]    nib_data = 4'h0;
    logic [SW-1:0] slot_idx = '0;
    logic          wr_en;
    logic [AW-3:0] wr_addr;
    logic [31:0]   wr_data;
    logic [3:0]    wr_be;
    logic          busy, done, overflow;

    always #5 clk = ~clk;

    stream_long_writer #(.ADDR_W(AW), .CNT_W(CW), .SLICE_W(SW), .QDEPTH(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .byte_count(byte_count), .coalesce(coalesce), .nib_valid(nib_valid),
        .nib_data(nib_data), .slot_idx(slot_idx), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_be(wr_be), .busy(busy), .done(done), .overflow(overflow)
    );

    int n_chk = 0, n_bad = 0;
    logic [7:0] got_mem [256];
    int         wcount  [256];
    logic [3:0] nib_arr [1024];
    int  t_start, t_end, t_next, t_cnt, n_writes;
    bit  t_mode, rot, allow_done, done_seen, last_final;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [3:0] nib_val(int i);
        return (i < 2 * t_cnt) ? nib_arr[i] : 4'h5;
    endfunction

    function automatic logic [7:0] exp_byte(int i);
        return {nib_arr[2*i+1], nib_arr[2*i]};
    endfunction

    // Write monitor: samples away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_en) begin
                int lane, nb, a;
                lane = 0;
                for (int k = 3; k >= 0; k--) if (wr_be[k]) lane = k;
                nb = $countones(wr_be);
                chk(wr_addr[SW-1:0] == slot_idx, "R2", "slice vs slot", int'(wr_addr[SW-1:0]), int'(slot_idx));
                chk(int'(wr_addr) * 4 + lane == t_next, "R7", "write start byte", int'(wr_addr) * 4 + lane, t_next);
                chk(wr_be == 4'(((1 << nb) - 1) << lane), "R6", "contiguous be", int'(wr_be), ((1 << nb) - 1) << lane);
                for (int k = 0; k < 4; k++) if (wr_be[k]) begin
                    a = int'(wr_addr) * 4 + k;
                    if (a < 256) begin
                        got_mem[a] = wr_data[8*k +: 8];
                        wcount[a]++;
                    end
                end
                if (t_mode && wr_be != 4'hF)
                    chk(n_writes == 0 || t_next + nb == t_end, "R5", "partial in middle", n_writes, 0);
                if (t_mode && (t_start % 4) == 0 && wr_be != 4'hF)
                    chk(t_next + nb == t_end, "R4", "aligned partial not tail", int'(wr_be), 15);
                t_next += nb;
                n_writes++;
            end
            if (last_final) chk(done == 1'b1, "R8", "done after last write", int'(done), 1);
            else if (done && !allow_done) chk(1'b0, "R8", "unexpected done", 1, 0);
            if (done) done_seen = 1'b1;
            last_final = wr_en && (t_next == t_end);
        end
    end

    task automatic cyc();
        @(posedge clk);
        #1;
        if (rot) slot_idx = slot_idx + 1'b1;
    endtask

    task automatic begin_xfer(int addr, int cnt, bit mode);
        t_start = addr; t_next = addr; t_end = addr + cnt; t_cnt = cnt;
        t_mode = mode; n_writes = 0; done_seen = 1'b0;
        for (int a = 0; a < 256; a++) begin wcount[a] = 0; got_mem[a] = 8'h00; end
        for (int i = 0; i < 2 * cnt; i++) nib_arr[i] = 4'($urandom % 16);
        start = 1'b1; start_addr = AW'(addr); byte_count = CW'(cnt); coalesce = mode;
        cyc();
        start = 1'b0;
    endtask

    task automatic run_stream(int from, int upto, int prob);
        int i;
        i = from;
        while (i < upto) begin
            bit v;
            v = ($urandom % 100) < prob;
            nib_valid = v;
            nib_data  = nib_val(i);
            cyc();
            if (v) i++;
        end
        nib_valid = 1'b0;
    endtask

    task automatic wait_done();
        int t;
        t = 0;
        while (!done_seen && t < 3000) begin cyc(); t++; end
        chk(done_seen, "R8", "done pulse seen", int'(done_seen), 1);
    endtask

    task automatic verify(string req);
        int bad, outside;
        bad = 0; outside = 0;
        for (int i = 0; i < t_cnt; i++)
            if (wcount[t_start+i] != 1 || got_mem[t_start+i] != exp_byte(i)) bad++;
        for (int a = 0; a < 256; a++)
            if ((a < t_start || a >= t_end) && wcount[a] != 0) outside++;
        chk(bad == 0, "R1", {req, " bytes match stream"}, bad, 0);
        chk(outside == 0, "R7", {req, " no writes outside range"}, outside, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "ALL", "watchdog expired", 1, 0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        rot = 1'b0; allow_done = 1'b0; last_final = 1'b0; t_end = -1; t_next = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !wr_en && !overflow, "R8", "reset state idle", int'({busy, done, wr_en, overflow}), 0);

        // R3: eager writes a lone byte at once, then merges held bytes
        cyc();
        slot_idx = 3'd0;
        begin_xfer(32'h40, 8, 1'b0);
        chk(busy == 1'b1, "R8", "busy after start", int'(busy), 1);
        run_stream(0, 2, 100);
        @(negedge clk);
        chk(wr_en && wr_be == 4'h1 && wr_data[7:0] == exp_byte(0), "R3", "eager single byte write", int'({wr_en, wr_be}), 5'h11);
        cyc();
        slot_idx = 3'd5;
        run_stream(2, 8, 100);
        slot_idx = 3'd0;
        @(negedge clk);
        chk(wr_en && wr_be == 4'hE, "R3", "eager merged bytes", int'(wr_be), 14);
        cyc();
        rot = 1'b1;
        run_stream(8, 20, 60);
        wait_done();
        verify("R3 eager directed");

        // R4: coalescing holds a single byte
        rot = 1'b0; slot_idx = 3'd0;
        begin_xfer(32'h40, 8, 1'b1);
        run_stream(0, 2, 100);
        @(negedge clk);
        chk(!wr_en, "R4", "coalesce holds partial long", int'(wr_en), 0);
        cyc();
        rot = 1'b1;
        run_stream(2, 20, 70);
        wait_done();
        verify("R4 coalesce directed");

        // R10: zero count
        rot = 1'b0; allow_done = 1'b1;
        begin_xfer(32'h10, 0, 1'b1);
        @(negedge clk);
        chk(done && !wr_en, "R10", "zero count done", int'({done, wr_en}), 2);
        cyc();
        cyc();
        chk(n_writes == 0, "R10", "no writes on zero count", n_writes, 0);

        // R9: overflow with slot held off the target slice
        slot_idx = 3'd7;
        begin_xfer(32'h0, 16, 1'b1);
        run_stream(0, 18, 100);
        @(negedge clk);
        chk(done && overflow, "R9", "overflow ends transfer", int'({done, overflow}), 3);
        chk(n_writes == 0, "R9", "no writes while blocked", n_writes, 0);
        cyc();
        cyc();
        chk(overflow == 1'b1, "R9", "overflow sticky while idle", int'(overflow), 1);
        allow_done = 1'b0;

        // R11: start while busy ignored; extra nibbles ignored; overflow cleared
        rot = 1'b1;
        begin_xfer(32'h23, 13, 1'b0);
        @(negedge clk);
        chk(overflow == 1'b0, "R9", "overflow cleared by start", int'(overflow), 0);
        cyc();
        run_stream(0, 9, 50);
        start = 1'b1; start_addr = AW'(32'h80); byte_count = CW'(5);
        cyc();
        start = 1'b0;
        run_stream(9, 2 * 13 + 6, 50);
        wait_done();
        verify("R11 start ignored");

        // Random transfers
        for (int it = 0; it < 40; it++) begin
            int addr, cnt, prob;
            bit mode;
            addr = $urandom % 180;
            cnt  = 1 + $urandom % 60;
            mode = 1'($urandom % 2);
            prob = 20 + $urandom % 30;
            slot_idx = 3'($urandom % 8);
            begin_xfer(addr, cnt, mode);
            run_stream(0, 2 * cnt + 4, prob);
            wait_done();
            verify(mode ? "R5 random coalesce" : "R3 random eager");
            chk(!busy, "R8", "idle after done", int'(busy), 0);
        end

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule